// File: doc/BRIEF.md
# Pulse-Aligned Tick Counter Bank

This block keeps a bank of 64-bit tick counters that run on the radio clock. Each counter adds one on every clock. Software reaches each counter through a 32-bit register port. To set the time, software first writes a 64-bit target value as two 32-bit halves. It then writes a command word that either copies the target into the counter at once or arms the counter. An armed counter takes the target on the next rising edge of a once-per-second reference pulse.

On every rising edge of the pulse, each counter records its value in a snapshot, so software can read the tick count at the last pulse. Each counter also holds a 64-bit period value that software can write and read back. A status bit flips on each rising edge of the pulse, and software confirms the pulse is present by watching that bit change. Reading the low half of the live count freezes the high half in a holding register, so a low-then-high read pair always gives one coherent 64-bit value.

The counters share one address space. Counter `i` starts at word address `BASE + STRIDE*i`. The pulse input is asynchronous and passes through a two-flop synchroniser before edge detection. Reads are a request/response pair with no back-pressure: a read request taken on one edge always produces a response on the next, and the requester must accept it.

Top module: `tick_keeper`

## Requirements
- R1: After reset every counter holds 0, and it adds one on every clock in which it is not being loaded.
- R2: A read at offset 0x00 returns bits 31:0 of the count as it stood on the edge that took the read, and copies bits 63:32 into a holding register. A read at offset 0x04 returns that holding register, not the live high half.
- R3: The target time is written at offsets 0x08 (bits 31:0) and 0x0C (bits 63:32). Both offsets are write-only and read back as 0.
- R4: Writing 1 to the command word at offset 0x10 loads the target into the counter on that edge. The counter then adds one per clock from the loaded value.
- R5: Writing 2 to the command word arms the counter. The target is loaded on the edge that acts on the next detected rising pulse edge. Arming then clears, and counting resumes from the loaded value.
- R6: Any command write other than 2 clears a pending arm. A value of 1 also loads at once. A command write takes priority over a pulse edge that falls on the same clock.
- R7: On each detected rising pulse edge, the count in that cycle is copied into a snapshot readable at offsets 0x14 (bits 31:0) and 0x18 (bits 63:32).
- R8: A 64-bit period is read/write at offsets 0x1C (bits 31:0) and 0x20 (bits 63:32), and resets to 0.
- R9: Bit 0 of the status word at offset 0x24 resets to 0 and flips once per rising pulse edge. It changes at no other time. A rise of the pulse input is acted on at the third clock edge after it, after two synchroniser flops and one edge-detect flop.
- R10: Counter `i` answers word addresses `BASE + STRIDE*i` through `BASE + STRIDE*i + STRIDE - 1`, and the counters act independently of one another. A read at any address outside every window, or at an unused offset, returns 0.
- R11: `rd_valid` is high exactly one cycle after each cycle with `rd_en` high, and `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Radio clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous once-per-second reference pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | REG_W | Register write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Register read word address |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | REG_W | Read response data |

## Verification
Some rules are checked by assertions on every cycle:
- each immediate load, and each armed load taken at a pulse edge;
- the plain add-one step;
- the snapshot capture at each edge;
- the status flip, and that the status bit holds between edges;
- the one-cycle read response and the zero data returned for unmapped reads.

Other behaviour only the directed scenarios can show:
- the exact three-edge latency from a pulse rise to a load;
- the holding register keeping a stale high half after the low half wraps;
- a later command write cancelling a pending arm;
- write-only offsets reading as zero;
- one counter being loaded while another is left untouched.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_NOW_LO  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_NOW_HI  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TGT_LO  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_TGT_HI  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_CMD     = 6'h10;
  localparam logic [OFF_W-1:0] OFF_SNAP_LO = 6'h14;
  localparam logic [OFF_W-1:0] OFF_SNAP_HI = 6'h18;
  localparam logic [OFF_W-1:0] OFF_PER_LO  = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_PER_HI  = 6'h20;
  localparam logic [OFF_W-1:0] OFF_STATUS  = 6'h24;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_NOW  = 2'd1,
    CMD_ARM  = 2'd2
  } tk_cmd_e;
endpackage

// File: rtl/tk_pps_sync.sv
module tk_pps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  output logic pps_edge,
  output logic pps_tog
);
  logic [STAGES-1:0] sync_q;
  logic              lvl_d;
  logic              edge_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      lvl_d  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pps_in};
      lvl_d  <= sync_q[STAGES-1];
      edge_q <= sync_q[STAGES-1] & ~lvl_d;
    end
  end

  assign pps_edge = sync_q[STAGES-1] & ~lvl_d;

  always_ff @(posedge clk) begin
    if (rst) pps_tog <= 1'b0;
    else if (pps_edge) pps_tog <= ~pps_tog;
  end

  assert_tog_flip_R9: assert property (@(posedge clk) disable iff (rst)
    edge_q |-> pps_tog != $past(pps_tog));
  assert_tog_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !pps_edge |=> $stable(pps_tog));
endmodule

// File: rtl/tk_core.sv
module tk_core
  import tk_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_hit,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_hit,
  input  logic [OFF_W-1:0] rd_off,
  input  logic             pps_edge,
  input  logic             pps_tog,
  output logic [REG_W-1:0] rd_word
);
  localparam int CNT_W = 2 * REG_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] snap_q;
  logic [REG_W-1:0] hi_hold_q;
  logic             armed_q;
  logic             cmd_wr;
  logic             wr_sel;

  assign wr_sel = wr_en & wr_hit;
  assign cmd_wr = wr_sel & (wr_off == OFF_CMD);

  // Counter, arming and load
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cmd_wr) begin
      armed_q <= (wr_data == REG_W'(CMD_ARM));
      if (wr_data == REG_W'(CMD_NOW)) cnt_q <= tgt_q;
      else cnt_q <= cnt_q + 1'b1;
    end else if (armed_q && pps_edge) begin
      armed_q <= 1'b0;
      cnt_q   <= tgt_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Target and period halves
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      per_q <= '0;
    end else if (wr_sel) begin
      case (wr_off)
        OFF_TGT_LO: tgt_q[REG_W-1:0]     <= wr_data;
        OFF_TGT_HI: tgt_q[CNT_W-1:REG_W] <= wr_data;
        OFF_PER_LO: per_q[REG_W-1:0]     <= wr_data;
        OFF_PER_HI: per_q[CNT_W-1:REG_W] <= wr_data;
        default: ;
      endcase
    end
  end

  // Snapshot at the pulse edge
  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else if (pps_edge) snap_q <= cnt_q;
  end

  // Registered readout with high-half holding
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word   <= '0;
      hi_hold_q <= '0;
    end else begin
      rd_word <= '0;
      if (rd_en && rd_hit) begin
        case (rd_off)
          OFF_NOW_LO: begin
            rd_word   <= cnt_q[REG_W-1:0];
            hi_hold_q <= cnt_q[CNT_W-1:REG_W];
          end
          OFF_NOW_HI:  rd_word <= hi_hold_q;
          OFF_SNAP_LO: rd_word <= snap_q[REG_W-1:0];
          OFF_SNAP_HI: rd_word <= snap_q[CNT_W-1:REG_W];
          OFF_PER_LO:  rd_word <= per_q[REG_W-1:0];
          OFF_PER_HI:  rd_word <= per_q[CNT_W-1:REG_W];
          OFF_STATUS:  rd_word <= {{(REG_W-1){1'b0}}, pps_tog};
          default:     rd_word <= '0;
        endcase
      end
    end
  end

  assert_load_now_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && wr_off == OFF_CMD && wr_data == REG_W'(1))
      |=> cnt_q == $past(tgt_q));
  assert_load_armed_R5: assert property (@(posedge clk) disable iff (rst)
    (armed_q && pps_edge && !(wr_en && wr_hit && wr_off == OFF_CMD))
      |=> (cnt_q == $past(tgt_q)) && !armed_q);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_hit && wr_off == OFF_CMD) && !(armed_q && pps_edge))
      |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_snap_take_R7: assert property (@(posedge clk) disable iff (rst)
    pps_edge |=> snap_q == $past(cnt_q));
  assert_cancel_arm_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && wr_off == OFF_CMD && wr_data != REG_W'(2)) |=> !armed_q);
endmodule

// File: rtl/tick_keeper.sv
module tick_keeper
  import tk_pkg::*;
#(
  parameter int NUM_KEEPERS = 2,
  parameter int ADDR_W      = 12,
  parameter int REG_W       = 32,
  parameter int BASE        = 100,
  parameter int STRIDE      = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data
);
  logic pps_edge;
  logic pps_tog;
  logic [REG_W-1:0]       words [NUM_KEEPERS];
  logic [NUM_KEEPERS-1:0] rd_hits;

  tk_pps_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pps_in   (pps_in),
    .pps_edge (pps_edge),
    .pps_tog  (pps_tog)
  );

  for (genvar i = 0; i < NUM_KEEPERS; i++) begin : g_keeper
    localparam int KBASE = BASE + STRIDE * i;
    logic             w_hit;
    logic             r_hit;
    logic [OFF_W-1:0] w_off;
    logic [OFF_W-1:0] r_off;
    logic [ADDR_W-1:0] w_rel;
    logic [ADDR_W-1:0] r_rel;

    assign w_hit = (wr_addr >= ADDR_W'(KBASE)) && (wr_addr < ADDR_W'(KBASE + STRIDE));
    assign r_hit = (rd_addr >= ADDR_W'(KBASE)) && (rd_addr < ADDR_W'(KBASE + STRIDE));
    assign w_rel = wr_addr - ADDR_W'(KBASE);
    assign r_rel = rd_addr - ADDR_W'(KBASE);
    assign w_off = OFF_W'(w_rel);
    assign r_off = OFF_W'(r_rel);
    assign rd_hits[i] = r_hit;

    tk_core #(.REG_W(REG_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_hit   (w_hit),
      .wr_off   (w_off),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_hit   (r_hit),
      .rd_off   (r_off),
      .pps_edge (pps_edge),
      .pps_tog  (pps_tog),
      .rd_word  (words[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_KEEPERS; k++) rd_data = rd_data | words[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else rd_valid <= rd_en;
  end

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hits == '0) |=> rd_data == '0);
endmodule

// File: tb/tick_keeper_bench.sv
module tick_keeper_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  AW = 12;
  localparam int  B0 = 100;
  localparam int  B1 = 148;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps_in = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_keeper u_tick_keeper (
    .clk(clk), .rst(rst), .pps_in(pps_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_wr(input int addr, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int addr, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    total++;
    if (rd_valid !== 1'b1) begin
      bad++;
      $display("FAIL R11: rd_valid got %b expected 1", rd_valid);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(B0 + 'h00, d); check("R1 count at reset", d, 32'd0);
    reg_rd(B0 + 'h00, d); check("R1 count one clock later", d, 32'd1);
    reg_rd(B0 + 'h04, d); check("R1 high half at reset", d, 32'd0);
    reg_rd(B0 + 'h1C, d); check("R8 period reset", d, 32'd0);
    reg_rd(B0 + 'h24, d); check("R9 status reset", d, 32'd0);
    step(1);
    total++;
    if (rd_valid !== 1'b0) begin
      bad++; $display("FAIL R11: idle rd_valid got %b expected 0", rd_valid);
    end
  endtask

  task automatic t_load_now_and_hold();
    logic [31:0] d;
    reg_wr(B0 + 'h08, 32'hFFFF_FFF0);
    reg_wr(B0 + 'h0C, 32'h0000_0005);
    reg_wr(B0 + 'h10, 32'd1);
    reg_rd(B0 + 'h00, d); check("R4 immediate load low", d, 32'hFFFF_FFF0);
    step(30);
    reg_rd(B0 + 'h04, d); check("R2 held high half after wrap", d, 32'h5);
    reg_rd(B0 + 'h00, d); check("R4 counting from loaded value", d, 32'h0000_0010);
    reg_rd(B0 + 'h04, d); check("R2 fresh high half", d, 32'h6);
  endtask

  task automatic t_arm_on_pulse();
    logic [31:0] d;
    reg_wr(B0 + 'h08, 32'h0000_0100);
    reg_wr(B0 + 'h0C, 32'h1234_0000);
    reg_wr(B0 + 'h10, 32'd2);
    step(5);
    pps_in = 1'b1;
    step(3);
    reg_rd(B0 + 'h00, d); check("R5 armed load low (R9 latency)", d, 32'h0000_0100);
    reg_rd(B0 + 'h04, d); check("R5 armed load high", d, 32'h1234_0000);
    pps_in = 1'b0;
    step(4);
  endtask

  task automatic t_cancel_arm();
    logic [31:0] d;
    reg_wr(B0 + 'h08, 32'h0000_0000);
    reg_wr(B0 + 'h0C, 32'h0000_00AB);
    reg_wr(B0 + 'h10, 32'd1);
    reg_wr(B0 + 'h10, 32'd2);
    reg_wr(B0 + 'h10, 32'd0);
    pps_in = 1'b1;
    step(3);
    reg_rd(B0 + 'h00, d); check("R6 cancelled arm keeps counting", d, 32'd5);
    reg_rd(B0 + 'h04, d); check("R6 high half untouched", d, 32'h0000_00AB);
    pps_in = 1'b0;
    step(4);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    reg_wr(B0 + 'h08, 32'h0000_1000);
    reg_wr(B0 + 'h0C, 32'h0000_0777);
    reg_wr(B0 + 'h10, 32'd1);
    pps_in = 1'b1;
    step(5);
    reg_rd(B0 + 'h14, d); check("R7 snapshot low", d, 32'h0000_1002);
    reg_rd(B0 + 'h18, d); check("R7 snapshot high", d, 32'h0000_0777);
    pps_in = 1'b0;
    step(4);
  endtask

  task automatic t_status();
    logic [31:0] d0, d;
    reg_rd(B0 + 'h24, d0);
    pps_in = 1'b1;
    step(5);
    reg_rd(B0 + 'h24, d); check("R9 status flips on rise", d, d0 ^ 32'd1);
    pps_in = 1'b0;
    step(6);
    reg_rd(B1 + 'h24, d); check("R9 status steady on fall", d, d0 ^ 32'd1);
  endtask

  task automatic t_period();
    logic [31:0] d;
    reg_wr(B0 + 'h1C, 32'hDEAD_BEEF);
    reg_wr(B0 + 'h20, 32'h0102_0304);
    reg_rd(B0 + 'h1C, d); check("R8 period low", d, 32'hDEAD_BEEF);
    reg_rd(B0 + 'h20, d); check("R8 period high", d, 32'h0102_0304);
    reg_rd(B1 + 'h1C, d); check("R10 other keeper period", d, 32'd0);
  endtask

  task automatic t_zero_reads();
    logic [31:0] d;
    reg_rd(B0 + 'h08, d); check("R3 target low reads 0", d, 32'd0);
    reg_rd(B0 + 'h0C, d); check("R3 target high reads 0", d, 32'd0);
    reg_rd(0, d);         check("R10 below window", d, 32'd0);
    reg_rd(200, d);       check("R10 above windows", d, 32'd0);
    reg_rd(B0 + 'h2C, d); check("R10 unused offset", d, 32'd0);
  endtask

  task automatic t_instances();
    logic [31:0] d;
    reg_wr(B0 + 'h08, 32'h0000_0000);
    reg_wr(B0 + 'h0C, 32'h0000_0009);
    reg_wr(B0 + 'h10, 32'd1);
    reg_wr(B1 + 'h08, 32'h0000_0050);
    reg_wr(B1 + 'h0C, 32'h0000_0003);
    reg_wr(B1 + 'h10, 32'd1);
    reg_rd(B0 + 'h00, d); check("R10 keeper0 unaffected", d, 32'd3);
    reg_rd(B1 + 'h00, d); check("R10 keeper1 loaded", d, 32'h0000_0051);
    reg_rd(B1 + 'h04, d); check("R10 keeper1 high", d, 32'h3);
    reg_rd(B0 + 'h04, d); check("R10 keeper0 high", d, 32'h9);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    t_reset();
    t_load_now_and_hold();
    t_arm_on_pulse();
    t_cancel_arm();
    t_snapshot();
    t_status();
    t_period();
    t_zero_reads();
    t_instances();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule